// File: doc/BRIEF.md
# IPv4 Destination Address Extractor

This block sits on the receive side of a packet path. It takes an Ethernet frame as a stream of bytes, one byte per valid cycle, with a start-of-frame flag on the first byte and an end-of-frame flag on the last byte. While the bytes pass, it counts them and captures the header fields it needs. It also accumulates the IPv4 header checksum. When the frame ends, it returns a single verdict.

The verdict is one record valid for one cycle. It holds a status code, a 16-bit parameter and the 32-bit destination address.

- A frame that carries a well-formed IPv4 header yields its destination address.
- Any other frame yields the first failing check together with the value that caused the failure.

Header options are allowed. They are not interpreted, but their bytes are covered by the checksum. Bytes after the end of the IP datagram, such as Ethernet padding, are accepted.

Top module: `ipv4_dst_extract`

## Requirements
- R1: For every input byte with `in_valid` and `in_eof` both high, `res_valid` is high for exactly one cycle, in the cycle after that byte. At all other times `res_valid` is low, including after reset.
- R2: A frame of fewer than 34 bytes gives code 1 (too short). The parameter is the number of bytes in the frame.
- R3: The type field is bytes 12 and 13 of the frame, counted from 0, with the most significant byte first. If it is not 0x0800, the result is code 2 (not IPv4) and the parameter is the type value.
- R4: The version is the upper nibble of frame byte 14. If it is not 4, the result is code 3 (bad version) and the parameter is the version value.
- R5: The header length is the lower nibble of frame byte 14, in 32-bit words. The total length is frame bytes 16 and 17, most significant byte first. The result is code 4 (bad length), with the total length as parameter, in any of these cases:
  - the header length is below 5;
  - the total length is below 4 × header length;
  - the total length exceeds the frame length minus 14.
- R6: The header occupies 4 × header length bytes starting at frame byte 14. They are read as big-endian 16-bit words and added with end-around carry. If the result is not 0xFFFF, the result is code 5 (bad checksum) and the parameter is the folded sum.
- R7: A frame that passes every check gives code 0. The destination is frame bytes 30..33 with the first byte most significant. The parameter is the header size in bytes, so a header with options is accepted.
- R8: When several checks fail, the lowest-numbered code is reported. The order is: too short, then type, then version, then length, then checksum.
- R9: On any error code, the reported destination is 0.
- R10: A byte with `in_sof` high starts a new frame at byte 0, even if the previous frame had no end marker. All earlier bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 3 | 0 ok, 1 too short, 2 not IPv4, 3 bad version, 4 bad length, 5 bad checksum |
| res_param | output | 16 | Frame length, type, version, total length, folded sum or header size, depending on the code |
| res_dst | output | 32 | IPv4 destination address, 0 on error |

## Verification
The checker runs on every cycle and enforces these properties:
- The result strobe is paired with an end marker in the previous cycle, and with nothing else.
- The code stays within its six values.
- An error result always carries a zero destination.
- A too-short result carries a length below 34.
- A success result carries a word-aligned header size between 20 and 60.

Other behaviour depends on the frame contents, so only the bench scenarios can show it. This covers the exact parameter values, the priority between failing checks, the checksum coverage of option bytes, and the restart of a frame when a new start marker arrives mid-frame. The bench compares each result against its own model of the rules, across random well-formed and damaged frames and a set of directed boundary frames.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
   typedef enum logic [2:0] {
      IPX_OK      = 3'd0,
      IPX_SHORT   = 3'd1,
      IPX_NOT_IP  = 3'd2,
      IPX_BAD_VER = 3'd3,
      IPX_BAD_LEN = 3'd4,
      IPX_BAD_SUM = 3'd5
   } ipx_code_e;

   localparam int ETH_HDR_BYTES = 14;
   localparam int IP_MIN_BYTES  = 20;
   localparam int MIN_FRAME     = ETH_HDR_BYTES + IP_MIN_BYTES;
   localparam logic [15:0] TYPE_IPV4 = 16'h0800;

   // captured byte slots: type hi/lo, version+ihl, total hi/lo, dst 0..3
   localparam int N_SLOTS = 9;

   function automatic int slot_pos(input int s);
      case (s)
         0: slot_pos = 12;
         1: slot_pos = 13;
         2: slot_pos = 14;
         3: slot_pos = 16;
         4: slot_pos = 17;
         default: slot_pos = 30 + (s - 5);
      endcase
   endfunction
endpackage

// File: rtl/ipx_byte_index.sv
module ipx_byte_index #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   output logic [CNT_W-1:0] cur_idx,
   output logic [CNT_W-1:0] cur_len
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      cur_idx = in_sof ? '0 : cnt_q;
      cur_len = (cur_idx == CNT_MAX) ? CNT_MAX : cur_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (in_valid) cnt_q <= cur_len;
   end
endmodule

// File: rtl/ipx_field_grab.sv
module ipx_field_grab
   import ipx_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [CNT_W-1:0] cur_idx,
   input  logic [7:0]       in_byte,
   output logic [7:0]       slot_nxt [N_SLOTS]
);
   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      localparam logic [CNT_W-1:0] POS = CNT_W'(slot_pos(s));
      logic [7:0] val_q;
      logic       hit;

      assign hit         = in_valid && (cur_idx == POS);
      assign slot_nxt[s] = hit ? in_byte : val_q;

      always_ff @(posedge clk) begin
         if (!rst_n) val_q <= '0;
         else        val_q <= slot_nxt[s];
      end
   end
endmodule

// File: rtl/ipx_csum.sv
module ipx_csum
   import ipx_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int SUM_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [CNT_W-1:0] cur_idx,
   input  logic [7:0]       in_byte,
   input  logic [3:0]       ihl_now,
   output logic [15:0]      sum_fold
);
   localparam logic [CNT_W-1:0] IP_START = CNT_W'(ETH_HDR_BYTES);

   logic [SUM_W-1:0] acc_q, acc_nxt;
   logic [CNT_W-1:0] ip_off;
   logic [15:0]      word_part;
   logic             in_hdr;
   logic [16:0]      fold1;
   logic [16:0]      fold2;

   always_comb begin
      ip_off    = cur_idx - IP_START;
      in_hdr    = in_valid && (cur_idx >= IP_START) &&
                  (ip_off < CNT_W'({ihl_now, 2'b00}));
      word_part = cur_idx[0] ? {8'h00, in_byte} : {in_byte, 8'h00};
      acc_nxt   = (in_valid && in_sof) ? '0 : acc_q;
      if (in_hdr) acc_nxt = acc_nxt + SUM_W'(word_part);
      fold1     = 17'(acc_nxt[15:0]) + 17'(acc_nxt[SUM_W-1:16]);
      fold2     = 17'(fold1[15:0]) + 17'(fold1[16]);
      sum_fold  = fold2[15:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_nxt;
   end
endmodule

// File: rtl/ipv4_dst_extract.sv
module ipv4_dst_extract
   import ipx_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_sof,
   input  logic        in_eof,
   input  logic [7:0]  in_byte,
   output logic        res_valid,
   output logic [2:0]  res_code,
   output logic [15:0] res_param,
   output logic [31:0] res_dst
);
   localparam int SUM_W = 21;
   localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_FRAME);

   initial begin
      if (CNT_W < 6 || CNT_W > 16)
         $error("CNT_W must lie in 6..16");
   end

   logic [CNT_W-1:0] cur_idx, cur_len;
   logic [7:0]       slot [N_SLOTS];
   logic [15:0]      sum_fold;

   ipx_byte_index #(.CNT_W(CNT_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .cur_idx(cur_idx), .cur_len(cur_len));

   ipx_field_grab #(.CNT_W(CNT_W)) u_grab (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_idx(cur_idx),
      .in_byte(in_byte), .slot_nxt(slot));

   ipx_csum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .cur_idx(cur_idx), .in_byte(in_byte), .ihl_now(slot[2][3:0]),
      .sum_fold(sum_fold));

   logic [15:0] etype, tot_len, hdr_bytes;
   logic [3:0]  ver, ihl;
   logic [31:0] dst;
   logic [16:0] avail;
   ipx_code_e   code_c;
   logic [15:0] param_c;
   logic [31:0] dst_c;

   always_comb begin
      etype     = {slot[0], slot[1]};
      ver       = slot[2][7:4];
      ihl       = slot[2][3:0];
      tot_len   = {slot[3], slot[4]};
      dst       = {slot[5], slot[6], slot[7], slot[8]};
      hdr_bytes = {10'd0, ihl, 2'b00};
      avail     = 17'(cur_len) - 17'(ETH_HDR_BYTES);
      dst_c     = '0;
      if (cur_len < MIN_LEN) begin
         code_c  = IPX_SHORT;
         param_c = 16'(cur_len);
      end else if (etype != TYPE_IPV4) begin
         code_c  = IPX_NOT_IP;
         param_c = etype;
      end else if (ver != 4'd4) begin
         code_c  = IPX_BAD_VER;
         param_c = {12'd0, ver};
      end else if (ihl < 4'd5 || tot_len < hdr_bytes ||
                   17'(tot_len) > avail) begin
         code_c  = IPX_BAD_LEN;
         param_c = tot_len;
      end else if (sum_fold != 16'hFFFF) begin
         code_c  = IPX_BAD_SUM;
         param_c = sum_fold;
      end else begin
         code_c  = IPX_OK;
         param_c = hdr_bytes;
         dst_c   = dst;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_code  <= '0;
         res_param <= '0;
         res_dst   <= '0;
      end else begin
         res_valid <= in_valid && in_eof;
         if (in_valid && in_eof) begin
            res_code  <= code_c;
            res_param <= param_c;
            res_dst   <= dst_c;
         end
      end
   end
endmodule

// File: rtl/ipx_checker.sv
module ipx_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_eof,
   input logic        res_valid,
   input logic [2:0]  res_code,
   input logic [15:0] res_param,
   input logic [31:0] res_dst
);
   // R1
   eof_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> res_valid);
   // R1
   result_has_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid && in_eof));
   // R8
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_code <= 3'd5));
   // R9
   err_dst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code != 3'd0) |-> (res_dst == 32'd0));
   // R2
   short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 3'd1) |-> (res_param >= 16'd1 && res_param < 16'd34));
   // R7
   ok_hdr_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 3'd0) |->
      (res_param >= 16'd20 && res_param <= 16'd60 && res_param[1:0] == 2'b00));
endmodule

bind ipv4_dst_extract ipx_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
   .res_valid(res_valid), .res_code(res_code), .res_param(res_param),
   .res_dst(res_dst));

// File: tb/ipv4_dst_extract_test.sv
module ipv4_dst_extract_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        res_valid;
   logic [2:0]  res_code;
   logic [15:0] res_param;
   logic [31:0] res_dst;

   int checks = 0;
   int fails  = 0;

   logic [7:0] fb [0:255];
   int         flen;

   always #5 clk = ~clk;

   ipv4_dst_extract uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_byte(in_byte), .res_valid(res_valid),
      .res_code(res_code), .res_param(res_param), .res_dst(res_dst));

   function automatic logic [15:0] hdr_sum(input int nbytes);
      logic [31:0] s = 0;
      for (int i = 0; i < nbytes; i += 2)
         s += {16'd0, fb[14+i], fb[15+i]};
      while (s[31:16] != 0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
      return s[15:0];
   endfunction

   task automatic build(input int ihl, input int pay, input int pad);
      logic [15:0] s;
      int tot = ihl*4 + pay;
      flen = 14 + tot + pad;
      for (int i = 0; i < flen; i++) fb[i] = 8'($urandom);
      fb[12] = 8'h08; fb[13] = 8'h00;
      fb[14] = {4'd4, 4'(ihl)};
      fb[16] = tot[15:8]; fb[17] = tot[7:0];
      fb[24] = 0; fb[25] = 0;
      s = ~hdr_sum(ihl*4);
      fb[24] = s[15:8]; fb[25] = s[7:0];
   endtask

   task automatic model(output logic [2:0] c, output logic [15:0] p,
                        output logic [31:0] d);
      int ihl = fb[14][3:0];
      int tot = {fb[16], fb[17]};
      logic [15:0] s;
      d = 0;
      if (flen < 34) begin c = 1; p = 16'(flen); end
      else if ({fb[12], fb[13]} != 16'h0800) begin c = 2; p = {fb[12], fb[13]}; end
      else if (fb[14][7:4] != 4) begin c = 3; p = {12'd0, fb[14][7:4]}; end
      else if (ihl < 5 || tot < ihl*4 || tot > flen - 14) begin c = 4; p = 16'(tot); end
      else begin
         s = hdr_sum(ihl*4);
         if (s != 16'hFFFF) begin c = 5; p = s; end
         else begin c = 0; p = 16'(ihl*4); d = {fb[30], fb[31], fb[32], fb[33]}; end
      end
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input int n, input bit with_eof);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1; in_byte = fb[i];
         in_sof = (i == 0); in_eof = with_eof && (i == n-1);
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
   endtask

   task automatic run_frame(input string tag);
      logic [2:0] c; logic [15:0] p; logic [31:0] d;
      model(c, p, d);
      push(flen, 1);
      chk({tag, " R1 valid"}, {63'd0, res_valid}, 64'd1);
      chk({tag, " code/param/dst"}, {13'd0, res_code, res_param, res_dst},
          {13'd0, c, p, d});
      @(negedge clk);
      chk({tag, " R1 pulse ends"}, {63'd0, res_valid}, 64'd0);
   endtask

   task automatic expect_code(input string tag, input logic [2:0] c);
      logic [2:0] mc; logic [15:0] mp; logic [31:0] md;
      model(mc, mp, md);
      chk({tag, " expected code"}, {61'd0, mc}, {61'd0, c});
      run_frame(tag);
   endtask

   task automatic finish_run;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 reset valid low", {63'd0, res_valid}, 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 idle valid low", {63'd0, res_valid}, 64'd0);

      build(5, 0, 0);   expect_code("R7 minimal 34-byte", 0);
      build(5, 0, 0); flen = 33; expect_code("R2 33 bytes", 1);
      build(5, 0, 0); flen = 1;  expect_code("R2 single byte", 1);
      build(15, 8, 6);  expect_code("R7 options ihl15 padded", 0);
      build(5, 4, 0); fb[12] = 8'h86; fb[13] = 8'hDD; expect_code("R3 type", 2);
      build(5, 4, 0); fb[14] = 8'h65; expect_code("R4 version", 3);
      build(5, 4, 0); fb[12] = 8'h81; fb[14] = 8'h65; expect_code("R8 type before version", 2);
      build(5, 4, 0); fb[14] = 8'h44; expect_code("R5 ihl4", 4);
      build(5, 4, 0); fb[17] = fb[17] + 8'd1; expect_code("R5 total too big", 4);
      build(6, 0, 8); fb[16] = 0; fb[17] = 8'd20; expect_code("R5 total below hdr", 4);
      build(8, 2, 0); fb[45] = fb[45] ^ 8'h01; expect_code("R6 option byte flipped", 5);
      build(5, 0, 0); fb[22] = fb[22] ^ 8'h80; expect_code("R6 ttl flipped", 5);
      build(5, 3, 0); fb[22] = fb[22] ^ 8'h10; fb[17] = 8'd99; expect_code("R8 length before checksum", 4);

      // R10: aborted frame without end marker, then a fresh frame
      build(5, 0, 0); fb[12] = 8'h00;
      push(20, 0);
      chk("R10 no result on abort", {63'd0, res_valid}, 64'd0);
      build(6, 5, 3); expect_code("R10 restart frame", 0);

      for (int n = 0; n < 300; n++) begin
         int kind = int'($urandom_range(0, 6));
         build(int'($urandom_range(5, 15)), int'($urandom_range(0, 20)),
               int'($urandom_range(0, 10)));
         case (kind)
            1: flen = int'($urandom_range(1, 33));
            2: fb[13] = fb[13] | 8'h01;
            3: fb[14][7:4] = 4'($urandom_range(5, 15));
            4: fb[14][3:0] = 4'($urandom_range(0, 4));
            5: fb[23] = fb[23] ^ 8'h04;
            default: ;
         endcase
         run_frame("R2..R9 random");
      end
      finish_run();
   end
endmodule